// File: doc/BRIEF.md
# Debug Streaming Memory Read Port

This block serves one register in a debug host's register space: the memory-data register. Each host read of that register fetches one byte from memory, then advances the processor's program counter. The read address comes from the program counter itself. Because the register address never moves, a host can read that single register over and over and receive a run of consecutive memory bytes.

There are two ways to form the address. Linear mode uses all 24 program-counter bits. Segmented mode uses only the low 16 bits of the program counter and takes the upper address byte from an 8-bit base input. The host can load the program counter directly. Memory is a plain synchronous read port: the byte arrives one cycle after the request.

Top module: `dbg_mrd_port`

## Requirements
- R1: A cycle with `rd_stb` high and `rd_reg` equal to the memory-data register address (`MEMRD_REG`, default 8'h20) raises `mem_req` in that same cycle.
- R2: When `lin_mode` is 1, `mem_addr` during a request equals the 24-bit program counter.
- R3: When `lin_mode` is 0, `mem_addr` during a request is `{base_i, pc[15:0]}`.
- R4: In linear mode, each memory-data read adds one to the program counter at the clock edge that ends the request cycle. The count wraps from 24'hFFFFFF to 24'h000000.
- R5: In segmented mode, each memory-data read adds one to `pc[15:0]` only. The low half wraps from 16'hFFFF to 16'h0000, and `pc[23:16]` does not change.
- R6: A strobe to any other register address, or a cycle with no strobe, leaves `mem_req` low and leaves the program counter unchanged.
- R7: `rd_done` is high for exactly one cycle, in the cycle after each request. In that cycle `rd_data` carries `mem_rdata`. In every other cycle `rd_data` is zero.
- R8: `pc_ld` loads `pc_ld_val` into the program counter and takes priority over an increment in the same cycle. A read in that cycle still uses the counter value from before the load.
- R9: After reset the program counter is 0, and `rd_done` and `mem_req` are low.
- R10: Strobes in back-to-back cycles each return the next byte of memory, with one byte completing per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Host register read strobe |
| rd_reg | input | 8 | Host register address |
| lin_mode | input | 1 | 1 = linear 24-bit address, 0 = base plus 16-bit address |
| base_i | input | 8 | Upper address byte used in segmented mode |
| pc_ld | input | 1 | Program counter load enable |
| pc_ld_val | input | 24 | Program counter load value |
| pc_q | output | 24 | Current program counter |
| rd_data | output | 8 | Read data to the host |
| rd_done | output | 1 | Read data valid pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the request |

## Verification
The bench uses a memory model whose contents depend on every address bit. A wrong upper byte, a stale counter or an off-by-one address therefore returns a different byte.

- **Directed cases:** streaming runs with strobes in back-to-back cycles; counters loaded just below the 24-bit and 16-bit wrap points; a load and a read in the same cycle; strobes to other register addresses.
- **Random cases:** mixed strobes, loads, addresses and mode changes, generated from a fixed seed.

Each case type separates a different fault:
- Back-to-back runs expose lost or doubled increments.
- The two wrap points show whether a carry crosses into the upper byte.
- Mode switches between reads show that the base byte is used only in segmented mode.
- Foreign addresses show a decode that is too wide.

// File: rtl/dbg_mrd_pkg.sv
package dbg_mrd_pkg;

   typedef enum logic {
      MODE_SEG = 1'b0,
      MODE_LIN = 1'b1
   } addr_mode_e;

   // Increment only the low seg_w bits of a value, keeping the high bits.
   function automatic logic [63:0] seg_bump(input logic [63:0] v, input int seg_w);
      logic [63:0] mask;
      mask = (64'd1 << seg_w) - 64'd1;
      return (v & ~mask) | ((v + 64'd1) & mask);
   endfunction

endpackage

// File: rtl/dbg_mrd_ctrl.sv
module dbg_mrd_ctrl #(
   parameter int REG_AW    = 8,
   parameter int DATA_W    = 8,
   parameter int MEMRD_REG = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [REG_AW-1:0] rd_reg,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              hit,
   output logic              done,
   output logic [DATA_W-1:0] data
);

   localparam logic [REG_AW-1:0] REG_SEL = REG_AW'(MEMRD_REG);

   generate
      if (MEMRD_REG < 0 || MEMRD_REG >= (1 << REG_AW)) begin : g_bad_reg
         $error("MEMRD_REG does not fit in REG_AW bits");
      end
   endgenerate

   logic done_q;

   assign hit = rd_stb && (rd_reg == REG_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else begin
         done_q <= hit;
      end
   end

   assign done = done_q;
   assign data = done_q ? mem_rdata : '0;

   p_done_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> done);
   p_done_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rd_stb));
   p_idle_data_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (data == '0));

endmodule

// File: rtl/dbg_mrd_pc.sv
module dbg_mrd_pc
   import dbg_mrd_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int SEG_W   = 16,
   parameter bit HAS_SEG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              inc,
   input  addr_mode_e        mode,
   output logic [ADDR_W-1:0] pc
);

   localparam int HI_W = ADDR_W - SEG_W;

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_inc;

   generate
      if (HAS_SEG) begin : g_seg
         logic [ADDR_W-1:0] seg_next;
         assign seg_next = {pc_q[ADDR_W-1:SEG_W], pc_q[SEG_W-1:0] + SEG_W'(1)};
         assign pc_inc   = (mode == MODE_LIN) ? pc_q + ADDR_W'(1) : seg_next;
      end else begin : g_lin
         assign pc_inc = pc_q + ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (ld) begin
         pc_q <= ld_val;
      end else if (inc) begin
         pc_q <= pc_inc;
      end
   end

   assign pc = pc_q;

   p_ld_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> pc == $past(ld_val));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !inc) |=> $stable(pc));
   p_lin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && inc && mode == MODE_LIN) |=> pc == $past(pc) + ADDR_W'(1));
   p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && inc && mode == MODE_SEG && HAS_SEG) |=>
         pc[ADDR_W-1:SEG_W] == $past(pc[ADDR_W-1:SEG_W]));

   initial begin
      assert (HI_W > 0) else $error("SEG_W must be below ADDR_W");
   end

endmodule

// File: rtl/dbg_mrd_addr.sv
module dbg_mrd_addr
   import dbg_mrd_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int SEG_W   = 16,
   parameter bit HAS_SEG = 1'b1
) (
   input  logic [ADDR_W-1:0]       pc,
   input  logic [ADDR_W-SEG_W-1:0] base,
   input  addr_mode_e              mode,
   output logic [ADDR_W-1:0]       addr
);

   generate
      if (HAS_SEG) begin : g_seg
         assign addr = (mode == MODE_LIN) ? pc : {base, pc[SEG_W-1:0]};
      end else begin : g_lin
         logic unused_base;
         assign unused_base = ^{base, mode};
         assign addr = pc;
      end
   endgenerate

endmodule

// File: rtl/dbg_mrd_port.sv
module dbg_mrd_port
   import dbg_mrd_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int SEG_W     = 16,
   parameter int DATA_W    = 8,
   parameter int REG_AW    = 8,
   parameter int MEMRD_REG = 32,
   parameter bit HAS_SEG   = 1'b1,
   localparam int BASE_W   = ADDR_W - SEG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [REG_AW-1:0] rd_reg,
   input  logic              lin_mode,
   input  logic [BASE_W-1:0] base_i,
   input  logic              pc_ld,
   input  logic [ADDR_W-1:0] pc_ld_val,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_done,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata
);

   addr_mode_e        mode;
   logic              hit;
   logic [ADDR_W-1:0] pc;

   assign mode = lin_mode ? MODE_LIN : MODE_SEG;

   dbg_mrd_ctrl #(
      .REG_AW   (REG_AW),
      .DATA_W   (DATA_W),
      .MEMRD_REG(MEMRD_REG)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (rd_stb),
      .rd_reg   (rd_reg),
      .mem_rdata(mem_rdata),
      .hit      (hit),
      .done     (rd_done),
      .data     (rd_data)
   );

   dbg_mrd_pc #(
      .ADDR_W (ADDR_W),
      .SEG_W  (SEG_W),
      .HAS_SEG(HAS_SEG)
   ) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (pc_ld),
      .ld_val(pc_ld_val),
      .inc   (hit),
      .mode  (mode),
      .pc    (pc)
   );

   dbg_mrd_addr #(
      .ADDR_W (ADDR_W),
      .SEG_W  (SEG_W),
      .HAS_SEG(HAS_SEG)
   ) u_addr (
      .pc  (pc),
      .base(base_i),
      .mode(mode),
      .addr(mem_addr)
   );

   assign mem_req = hit;
   assign pc_q    = pc;

   p_req_only_on_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> rd_stb);
   p_req_moves_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !pc_ld) |=> pc_q != $past(pc_q));
   p_lin_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && lin_mode) |-> mem_addr == pc_q);
   p_seg_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !lin_mode) |-> mem_addr[SEG_W-1:0] == pc_q[SEG_W-1:0]);

endmodule

// File: tb/dbg_mrd_port_bench.sv
`timescale 1ns/1ps
module dbg_mrd_port_bench;

   localparam logic [7:0] MEMRD = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_stb = 1'b0;
   logic [7:0]  rd_reg = '0;
   logic        lin_mode = 1'b1;
   logic [7:0]  base_i = '0;
   logic        pc_ld = 1'b0;
   logic [23:0] pc_ld_val = '0;
   logic [23:0] pc_q;
   logic [7:0]  rd_data;
   logic        rd_done;
   logic        mem_req;
   logic [23:0] mem_addr;
   logic [7:0]  mem_rdata = '0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [23:0] m_pc = '0;
   logic        pend = 1'b0;
   logic [7:0]  pend_data = '0;

   always #2.5 clk = ~clk;

   dbg_mrd_port u_dbg_mrd_port (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_reg(rd_reg),
      .lin_mode(lin_mode), .base_i(base_i), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val),
      .pc_q(pc_q), .rd_data(rd_data), .rd_done(rd_done), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] memf(input logic [23:0] a);
      return (a[7:0] + a[15:8] * 8'd3 + a[23:16] * 8'd7) ^ 8'h5A;
   endfunction

   always @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic stb, input logic [7:0] rg, input logic ld,
                       input logic [23:0] lv, input logic lin, input logic [7:0] bs);
      logic        hit;
      logic [23:0] ea;
      logic [23:0] npc;
      string       pct;
      rd_stb = stb; rd_reg = rg; pc_ld = ld; pc_ld_val = lv; lin_mode = lin; base_i = bs;
      #1;
      hit = stb && (rg == MEMRD);
      ea  = lin ? m_pc : {bs, m_pc[15:0]};
      chk(mem_req == hit, hit ? "R1" : "R6", 32'(mem_req), 32'(hit));
      if (hit) chk(mem_addr == ea, lin ? "R2" : "R3", 32'(mem_addr), 32'(ea));
      if (ld) begin npc = lv; pct = "R8"; end
      else if (hit && lin) begin npc = m_pc + 24'd1; pct = "R4"; end
      else if (hit) begin npc = {m_pc[23:16], m_pc[15:0] + 16'd1}; pct = "R5"; end
      else begin npc = m_pc; pct = "R6"; end
      @(negedge clk);
      m_pc = npc;
      chk(rd_done == hit, "R7", 32'(rd_done), 32'(hit));
      chk(rd_data == (hit ? memf(ea) : 8'h00), "R10", 32'(rd_data), 32'(hit ? memf(ea) : 8'h00));
      chk(pc_q == m_pc, pct, 32'(pc_q), 32'(m_pc));
      pend = hit; pend_data = memf(ea);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pc_q == 24'd0, "R9", 32'(pc_q), 0);
      chk(rd_done == 1'b0, "R9", 32'(rd_done), 0);
      chk(mem_req == 1'b0, "R9", 32'(mem_req), 0);

      // R10 streaming in linear mode
      for (int i = 0; i < 8; i++) step(1, MEMRD, 0, 0, 1, 8'h00);
      // R4 linear wrap
      step(0, 0, 1, 24'hFFFFFE, 1, 0);
      for (int i = 0; i < 4; i++) step(1, MEMRD, 0, 0, 1, 8'hA5);
      // R5 segmented wrap keeps upper byte
      step(0, 0, 1, 24'h3CFFFE, 0, 0);
      for (int i = 0; i < 4; i++) step(1, MEMRD, 0, 0, 0, 8'h71);
      // R3 mode switch between reads
      step(1, MEMRD, 0, 0, 1, 8'h71);
      step(1, MEMRD, 0, 0, 0, 8'h12);
      // R8 load and read together
      step(1, MEMRD, 1, 24'h456789, 1, 0);
      step(1, MEMRD, 1, 24'h00FFFF, 0, 8'h09);
      step(1, MEMRD, 0, 0, 0, 8'h09);
      // R6 foreign addresses
      step(1, 8'h21, 0, 0, 1, 0);
      step(1, 8'h1F, 0, 0, 0, 8'hFF);
      step(0, MEMRD, 0, 0, 1, 0);
      step(1, 8'hA0, 0, 0, 1, 0);

      for (int i = 0; i < 400; i++) begin
         logic        s;
         logic [7:0]  r;
         logic        l;
         logic [23:0] v;
         s = ($urandom % 4) != 0;
         r = (($urandom % 5) != 0) ? MEMRD : 8'($urandom);
         l = ($urandom % 10) == 0;
         v = (($urandom % 2) != 0) ? (24'hFFFFF0 | 24'($urandom % 16)) : 24'($urandom);
         step(s, r, l, v, 1'($urandom), 8'($urandom));
      end
      step(0, 0, 0, 0, 1, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule